// File: doc/BRIEF.md
# Dual-Comparator Compare-Match Timer

This block is an up-counter with two comparators and one output pin. While it is enabled in its compare-match mode, the counter climbs by one per clock. It wraps back to zero on one of two events, and a clear-select input chooses which: the coarse P comparator, or the full-width A comparator. Each comparator event can set a sticky interrupt flag. Software clears a flag by pulsing a clear input.

The pin changes only when the A comparator fires. A 2-bit action code chooses whether the pin goes low, goes high, toggles or holds. Each rising edge of the enable loads a chosen starting level into the pin. The P comparator looks only at the top bits of the counter. A P value of zero means the counter runs to full scale and wraps by overflowing. The mode input has room for several timer modes, but only code 00 (compare-match) makes the counter run.

Top module: `dual_cmp_timer`

## Requirements
- R1: While the enable is 1 and the mode is 00, the count starts at 0 on the first enabled cycle and rises by one on every clock until a clear event.
- R2: While the enable is 0 or the mode is not 00, the count is held at 0 and neither flag is set.
- R3: With clear-select 0 and a non-zero P value p, the count wraps to 0 on the clock after it reaches p×128 (the 3-bit P value is compared with count bits 9:7, and bits 6:0 are zero at that moment). The P flag is set on that same clock.
- R4: With clear-select 0 and a P value of 0, the count runs up to 1023 and wraps to 0 on the next clock, and that overflow sets the P flag.
- R5: With clear-select 0, the count reaching the A value sets the A flag on the next clock and does not clear the count.
- R6: With clear-select 1, the count wraps to 0 on the clock after it reaches the A value, and the A flag is set. The P flag is never set, even when the P point lies below the A value.
- R7: On an A match, the pin follows the action code: 00 holds, 01 drives 0, 10 drives 1, 11 inverts the pin.
- R8: A P match or an overflow leaves the pin unchanged, and the pin holds its level while the block is disabled.
- R9: On the clock that samples the enable rising from 0 to 1, the pin takes the value of the initial-level input.
- R10: An A value of 0 never produces an A match, so it sets no A flag and changes no pin.
- R11: Each flag stays at 1 once set, until its clear input is sampled at 1. Clearing one flag leaves the other as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter enable |
| mode | input | 2 | Mode code; only 00 runs |
| clr_sel | input | 1 | 0: clear on P match or overflow; 1: clear on A match |
| act | input | 2 | Pin action taken on an A match |
| init_lvl | input | 1 | Pin level loaded on a rising edge of en |
| cmp_a | input | 10 | A compare value (full width) |
| cmp_p | input | 3 | P compare value (top counter bits) |
| clr_af | input | 1 | Clears the A flag when 1 |
| clr_pf | input | 1 | Clears the P flag when 1 |
| count | output | 10 | Counter value |
| flag_a | output | 1 | Sticky A-match flag |
| flag_p | output | 1 | Sticky P-match flag |
| pin_out | output | 1 | Compare output pin |

## Verification
The main function is driven by a table of configurations. Each one starts from a fresh enable edge and is sampled after a chosen number of clocks.

- With clear-select 0, an A value below the P point shows an A match that does not clear the count. An A value above the P point shows that the count wraps before A is reached.
- With clear-select 1, a P value below A shows that the P flag stays quiet.
- A P value of zero separates overflow wrapping from P-match wrapping.
- Runs long enough for two A matches show that toggle differs from a set or a clear.
- A run with action code 00 and a run with A equal to 0 show that the pin and the A flag can stay untouched.

Directed steps then cover the non-compare mode, flag hold across disable, and the clear inputs acting on one flag at a time.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CW = 10,
  parameter int PW = 3,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [MW-1:0] mode,
  input  logic          clr_sel,
  input  logic [1:0]    act,
  input  logic          init_lvl,
  input  logic [CW-1:0] cmp_a,
  input  logic [PW-1:0] cmp_p,
  input  logic          clr_af,
  input  logic          clr_pf,
  output logic [CW-1:0] count,
  output logic          flag_a,
  output logic          flag_p,
  output logic          pin_out
);
  localparam int LW = CW - PW;
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic en_q, run, en_rise, a_hit, p_hit, wrap;

  assign run     = en && (mode == '0);
  assign en_rise = en && !en_q;
  assign a_hit   = run && (cmp_a != '0) && (count == cmp_a);
  assign p_hit   = run && ((cmp_p == '0) ? (count == FULL)
                                         : (count == {cmp_p, {LW{1'b0}}}));
  assign wrap    = clr_sel ? a_hit : p_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          count <= '0;
    else if (!run || wrap) count <= '0;
    else                 count <= count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_p <= 1'b0;
    end else begin
      if (a_hit)                 flag_a <= 1'b1;
      else if (clr_af)           flag_a <= 1'b0;
      if (p_hit && !clr_sel)     flag_p <= 1'b1;
      else if (clr_pf)           flag_p <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pin_out <= 1'b0;
    else if (en_rise) pin_out <= init_lvl;
    else if (a_hit)
      case (act)
        2'b01:   pin_out <= 1'b0;
        2'b10:   pin_out <= 1'b1;
        2'b11:   pin_out <= ~pin_out;
        default: pin_out <= pin_out;
      endcase

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
  a_r2_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !flag_a && !flag_p) |=> (!flag_a && !flag_p));
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap && count != FULL) |=> (count == $past(count) + 1'b1));
  a_r6_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr_sel && cmp_a != '0 && count == cmp_a) |=> (count == '0 && flag_a));
  a_r6_no_pflag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel && !flag_p) |=> !flag_p);
  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rise && !a_hit) |=> $stable(pin_out));
  a_r9_init_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q) |=> (pin_out == $past(init_lvl)));
  a_r11_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !clr_af) |=> flag_a);
endmodule

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr_sel = 1'b0, init_lvl = 1'b0;
  logic clr_af = 1'b0, clr_pf = 1'b0;
  logic [1:0] mode = 2'b00, act = 2'b00;
  logic [9:0] cmp_a = 10'd0;
  logic [2:0] cmp_p = 3'd0;
  logic [9:0] count;
  logic flag_a, flag_p, pin_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .clr_sel(clr_sel),
    .act(act), .init_lvl(init_lvl), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .clr_af(clr_af), .clr_pf(clr_pf), .count(count), .flag_a(flag_a),
    .flag_p(flag_p), .pin_out(pin_out));

  typedef struct packed {
    logic       csel;
    logic [1:0] act;
    logic       init;
    logic [9:0] a;
    logic [2:0] p;
    logic [10:0] n;
    logic [9:0] ecnt;
    logic       efa;
    logic       efp;
    logic       epin;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    {1'b0, 2'b10, 1'b0, 10'd5,    3'd1, 11'd6,    10'd6,   1'b1, 1'b0, 1'b1},
    {1'b0, 2'b01, 1'b1, 10'd5,    3'd1, 11'd6,    10'd6,   1'b1, 1'b0, 1'b0},
    {1'b0, 2'b11, 1'b0, 10'd3,    3'd1, 11'd4,    10'd4,   1'b1, 1'b0, 1'b1},
    {1'b0, 2'b11, 1'b0, 10'd3,    3'd1, 11'd133,  10'd4,   1'b1, 1'b1, 1'b0},
    {1'b0, 2'b00, 1'b1, 10'd3,    3'd1, 11'd10,   10'd10,  1'b1, 1'b0, 1'b1},
    {1'b1, 2'b10, 1'b0, 10'd7,    3'd1, 11'd8,    10'd0,   1'b1, 1'b0, 1'b1},
    {1'b1, 2'b11, 1'b1, 10'd200,  3'd1, 11'd201,  10'd0,   1'b1, 1'b0, 1'b0},
    {1'b0, 2'b10, 1'b0, 10'd1000, 3'd0, 11'd1024, 10'd0,   1'b1, 1'b1, 1'b1},
    {1'b0, 2'b01, 1'b1, 10'd1000, 3'd0, 11'd1000, 10'd1000,1'b0, 1'b0, 1'b1},
    {1'b0, 2'b10, 1'b0, 10'd300,  3'd2, 11'd257,  10'd0,   1'b0, 1'b1, 1'b0},
    {1'b0, 2'b01, 1'b1, 10'd0,    3'd1, 11'd140,  10'd11,  1'b0, 1'b1, 1'b1}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:    return "R1 R5 R7 R9";
      2, 3:    return "R3 R5 R7";
      4:       return "R7 R5";
      5, 6:    return "R6 R7";
      7:       return "R4 R7";
      8:       return "R4 R1";
      9:       return "R3 R8";
      default: return "R10 R8";
    endcase
  endfunction

  task automatic check(string req, int actual, int expected, string what);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic run_vec(int i);
    vec_t v = VECS[i];
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
    clr_af = 1'b1; clr_pf = 1'b1;
    @(negedge clk);
    clr_af = 1'b0; clr_pf = 1'b0;
    clr_sel = v.csel; act = v.act; init_lvl = v.init; cmp_a = v.a; cmp_p = v.p;
    @(negedge clk) en = 1'b1;
    repeat (int'(v.n)) @(posedge clk);
    @(negedge clk);
    check(vtag(i), count, v.ecnt, $sformatf("vec %0d count", i));
    check(vtag(i), flag_a, v.efa, $sformatf("vec %0d flag_a", i));
    check(vtag(i), flag_p, v.efp, $sformatf("vec %0d flag_p", i));
    check(vtag(i), pin_out, v.epin, $sformatf("vec %0d pin", i));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R2", count, 0, "reset count");
    check("R11", flag_a | flag_p, 0, "reset flags");
    check("R8", pin_out, 0, "reset pin");
    rst_n = 1'b1;

    // R2: a non-compare mode keeps the counter idle
    @(negedge clk) begin mode = 2'b01; cmp_a = 10'd3; cmp_p = 3'd1; en = 1'b1; end
    repeat (10) @(negedge clk);
    check("R2", count, 0, "mode 01 count");
    check("R2", flag_a | flag_p, 0, "mode 01 flags");
    @(negedge clk) begin en = 1'b0; mode = 2'b00; end

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8 R11: disabled hold, then independent clears
    @(negedge clk) en = 1'b0;
    repeat (5) @(negedge clk);
    check("R2", count, 0, "disabled count");
    check("R11", flag_p, 1, "p flag sticky");
    check("R8", pin_out, 1, "pin held while disabled");
    clr_af = 1'b1;
    @(negedge clk) clr_af = 1'b0;
    check("R11", flag_p, 1, "clear A leaves P");
    clr_pf = 1'b1;
    @(negedge clk) clr_pf = 1'b0;
    check("R11", flag_p, 0, "P cleared");

    // R11: A flag survives disable and clears alone
    run_vec(0);
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", flag_a, 1, "a flag sticky");
    clr_pf = 1'b1;
    @(negedge clk) clr_pf = 1'b0;
    check("R11", flag_a, 1, "clear P leaves A");
    clr_af = 1'b1;
    @(negedge clk) clr_af = 1'b0;
    check("R11", flag_a, 0, "A cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule